// File: doc/BRIEF.md
# CAN Interrupt Status and Mask Aggregator

This block sits beside a CAN controller and gathers its completion and error events into interrupt request flags. Every message slot has a status bit, a mask bit and a direction bit. The direction bit records whether the slot's last completion was a receive or a transmit. Three error conditions each have their own status bit and mask bit: a bus error was seen, the node went error-passive, and the node went bus-off. Events arrive on plain one-cycle strobes. Status bits stay set until software writes zero to them. The hardware never clears them.

A routing bit chooses between two output schemes. In separate mode, enabled events raise one of three sticky flags: transmit-complete, receive-complete or error. Slot events raise their flag again on every new completion. An error event raises the error flag only when no enabled error status bit was already set. In combined mode, every enabled event raises a single fourth flag, and error events re-trigger the same way slot events do. Software clears a flag by writing 1 to its bit in the request register.

The register port uses a write strobe with a 3-bit address. Read data is combinational from the address. Events and register writes are plain control pins with no handshake: the block accepts a strobe in any cycle and cannot apply back-pressure.

Top module: `can_irq_aggr`

## Requirements
- R1: While reset is asserted and after it is released, all registers read as zero and all four request outputs are 0.
- R2: The routing bit (address 0, bit 0; 1 = separate, 0 = combined), the slot mask (address 2, bit k = slot k, 1 = enabled) and the error mask (address 5, bits [2:0]) read back the value last written.
- R3: A slot event strobe on bit k sets slot status bit k (address 1) at the next edge, whatever the mask is. The same edge loads direction bit k (address 3) from the receive qualifier: 1 = receive, 0 = transmit.
- R4: A write to address 1 clears each status bit whose data bit is 0 and leaves bits written 1 unchanged. No other action clears a status bit. If an event and a clear hit the same bit in one cycle, the bit stays 1.
- R5: Error status (address 4) holds bus error in bit 0, error-passive in bit 1 and bus-off in bit 2. Each bit is set by the matching error strobe bit. A write clears each bit written 0. An event wins over a clear in the same cycle.
- R6: In separate mode, an enabled slot event with qualifier 0 sets the transmit flag (request bit 0, output irq_tx) at the next edge. One with qualifier 1 sets the receive flag (bit 1, irq_rx). This happens even if the slot's status bit was already 1.
- R7: In separate mode, an enabled error event sets the error flag (bit 2, irq_err) at the next edge only if no error status bit that is both set and enabled existed at the start of that cycle.
- R8: In combined mode, any enabled slot or error event sets the combined flag (bit 3, irq_comb) at the next edge, with no suppression. Flags 0 to 2 are not set.
- R9: Request flags are sticky. A write to address 6 clears each flag written 1. A flag set and a flag clear in the same cycle leave the flag set.
- R10: A slot or error event whose mask bit is 0 sets its status bit but raises no request flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| slot_evt | input | NSLOT | One-cycle completion strobe per message slot |
| slot_evt_rx | input | NSLOT | Per-slot qualifier for slot_evt: 1 = receive, 0 = transmit |
| err_evt | input | 3 | Error strobes: bit 0 bus error, bit 1 error-passive, bit 2 bus-off |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | NSLOT | Register write data |
| reg_rdata | output | NSLOT | Read data for reg_addr, combinational |
| irq_tx | output | 1 | Sticky transmit-complete request (separate mode) |
| irq_rx | output | 1 | Sticky receive-complete request (separate mode) |
| irq_err | output | 1 | Sticky error request (separate mode) |
| irq_comb | output | 1 | Sticky combined request (combined mode) |

## Verification
The hardest case to reach is error suppression while the mask and the status disagree. One example is a status bit that is set but masked, next to an enabled bit that is clear; another is a status clear that lands in the same cycle as a new error strobe. The random phase sends sparse events, occasional error strobes, and writes to both masks, both status registers, the routing bit and the request register, all mixed together. Masked and enabled status bits therefore sit side by side, and clears collide with events. Directed steps first produce a suppressed second error, the release after a clear, event-versus-clear collisions and slot re-triggering.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  localparam int ADDR_W = 3;
  localparam int ERR_W  = 3;
  localparam int REQ_W  = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 3'd0,
    A_SSTAT = 3'd1,
    A_SMASK = 3'd2,
    A_SDIR  = 3'd3,
    A_ESTAT = 3'd4,
    A_EMASK = 3'd5,
    A_REQ   = 3'd6,
    A_RSVD  = 3'd7
  } reg_addr_e;

  // request flag positions
  localparam int RQ_TX   = 0;
  localparam int RQ_RX   = 1;
  localparam int RQ_ERR  = 2;
  localparam int RQ_COMB = 3;
endpackage

// File: rtl/can_slot_bank.sv
module can_slot_bank #(
  parameter int NSLOT = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSLOT-1:0] evt,
  input  logic [NSLOT-1:0] evt_rx,
  input  logic [NSLOT-1:0] clr,
  input  logic             mask_we,
  input  logic [NSLOT-1:0] mask_wdata,
  output logic [NSLOT-1:0] stat,
  output logic [NSLOT-1:0] mask,
  output logic [NSLOT-1:0] dir,
  output logic             tx_pulse,
  output logic             rx_pulse
);
  logic [NSLOT-1:0] hit;

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stat[k] <= 1'b0;
        dir[k]  <= 1'b0;
      end else begin
        // event beats software clear
        if (evt[k])      stat[k] <= 1'b1;
        else if (clr[k]) stat[k] <= 1'b0;
        if (evt[k])      dir[k]  <= evt_rx[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask <= '0;
    else if (mask_we) mask <= mask_wdata;
  end

  assign hit      = evt & mask;
  assign tx_pulse = |(hit & ~evt_rx);
  assign rx_pulse = |(hit & evt_rx);

  a_r3_evt_sets_stat: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((stat & $past(evt)) == $past(evt)));
  a_r4_no_hw_clear: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~stat & $past(stat) & ~$past(clr)) == '0));
  a_r10_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt & mask) == '0) |-> !(tx_pulse || rx_pulse));
endmodule

// File: rtl/can_err_bank.sv
module can_err_bank
  import can_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ERR_W-1:0] evt,
  input  logic [ERR_W-1:0] clr,
  input  logic             mask_we,
  input  logic [ERR_W-1:0] mask_wdata,
  output logic [ERR_W-1:0] stat,
  output logic [ERR_W-1:0] mask,
  output logic             err_pulse,
  output logic             err_raw
);
  logic pending;

  for (genvar b = 0; b < ERR_W; b++) begin : g_ebit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stat[b] <= 1'b0;
      else if (evt[b]) stat[b] <= 1'b1;
      else if (clr[b]) stat[b] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask <= '0;
    else if (mask_we) mask <= mask_wdata;
  end

  assign pending   = |(stat & mask);
  assign err_raw   = |(evt & mask);
  assign err_pulse = err_raw & ~pending;

  a_r7_err_suppressed: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat & mask)) |-> !err_pulse);
  a_r5_evt_sets_stat: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((stat & $past(evt)) == $past(evt)));
  a_r5_no_hw_clear: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~stat & $past(stat) & ~$past(clr)) == '0));
endmodule

// File: rtl/can_req_flags.sv
module can_req_flags
  import can_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sep,
  input  logic             tx_p,
  input  logic             rx_p,
  input  logic             err_p,
  input  logic             err_raw,
  input  logic [REQ_W-1:0] clr,
  output logic [REQ_W-1:0] flags
);
  logic [REQ_W-1:0] set;

  always_comb begin
    set = '0;
    if (sep) begin
      set[RQ_TX]  = tx_p;
      set[RQ_RX]  = rx_p;
      set[RQ_ERR] = err_p;
    end else begin
      set[RQ_COMB] = tx_p | rx_p | err_raw;
    end
  end

  for (genvar f = 0; f < REQ_W; f++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flags[f] <= 1'b0;
      else if (set[f]) flags[f] <= 1'b1;
      else if (clr[f]) flags[f] <= 1'b0;
    end
  end

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~flags & $past(flags) & ~$past(clr)) == '0));
  a_r8_comb_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!sep && !flags[RQ_TX]) |=> !flags[RQ_TX]);
  a_r6_tx_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (sep && tx_p) |=> flags[RQ_TX]);
  a_r6_rx_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (sep && rx_p) |=> flags[RQ_RX]);
endmodule

// File: rtl/can_irq_aggr.sv
module can_irq_aggr
  import can_irq_pkg::*;
#(
  parameter int NSLOT = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSLOT-1:0]  slot_evt,
  input  logic [NSLOT-1:0]  slot_evt_rx,
  input  logic [ERR_W-1:0]  err_evt,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [NSLOT-1:0]  reg_wdata,
  output logic [NSLOT-1:0]  reg_rdata,
  output logic              irq_tx,
  output logic              irq_rx,
  output logic              irq_err,
  output logic              irq_comb
);
  localparam int PAD_CTRL = NSLOT - 1;
  localparam int PAD_ERR  = NSLOT - ERR_W;
  localparam int PAD_REQ  = NSLOT - REQ_W;

  reg_addr_e        addr;
  logic             sep_q;
  logic [NSLOT-1:0] sstat, smask, sdir, sclr;
  logic [ERR_W-1:0] estat, emask, eclr;
  logic [REQ_W-1:0] flags, rclr;
  logic             tx_p, rx_p, err_p, err_raw;

  assign addr = reg_addr_e'(reg_addr);
  assign sclr = (reg_wr && addr == A_SSTAT) ? ~reg_wdata : '0;
  assign eclr = (reg_wr && addr == A_ESTAT) ? ~reg_wdata[ERR_W-1:0] : '0;
  assign rclr = (reg_wr && addr == A_REQ)   ?  reg_wdata[REQ_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        sep_q <= 1'b0;
    else if (reg_wr && addr == A_CTRL) sep_q <= reg_wdata[0];
  end

  can_slot_bank #(.NSLOT(NSLOT)) u_slots (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt        (slot_evt),
    .evt_rx     (slot_evt_rx),
    .clr        (sclr),
    .mask_we    (reg_wr && addr == A_SMASK),
    .mask_wdata (reg_wdata),
    .stat       (sstat),
    .mask       (smask),
    .dir        (sdir),
    .tx_pulse   (tx_p),
    .rx_pulse   (rx_p)
  );

  can_err_bank u_errs (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt        (err_evt),
    .clr        (eclr),
    .mask_we    (reg_wr && addr == A_EMASK),
    .mask_wdata (reg_wdata[ERR_W-1:0]),
    .stat       (estat),
    .mask       (emask),
    .err_pulse  (err_p),
    .err_raw    (err_raw)
  );

  can_req_flags u_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .sep     (sep_q),
    .tx_p    (tx_p),
    .rx_p    (rx_p),
    .err_p   (err_p),
    .err_raw (err_raw),
    .clr     (rclr),
    .flags   (flags)
  );

  always_comb begin
    unique case (addr)
      A_CTRL:  reg_rdata = {{PAD_CTRL{1'b0}}, sep_q};
      A_SSTAT: reg_rdata = sstat;
      A_SMASK: reg_rdata = smask;
      A_SDIR:  reg_rdata = sdir;
      A_ESTAT: reg_rdata = {{PAD_ERR{1'b0}}, estat};
      A_EMASK: reg_rdata = {{PAD_ERR{1'b0}}, emask};
      A_REQ:   reg_rdata = {{PAD_REQ{1'b0}}, flags};
      default: reg_rdata = '0;
    endcase
  end

  assign irq_tx   = flags[RQ_TX];
  assign irq_rx   = flags[RQ_RX];
  assign irq_err  = flags[RQ_ERR];
  assign irq_comb = flags[RQ_COMB];

  a_r8_sep_quiet_comb: assert property (@(posedge clk) disable iff (!rst_n)
    (sep_q && !irq_comb) |=> !irq_comb);
endmodule

// File: tb/test_can_irq_aggr.sv
module test_can_irq_aggr;
  localparam int NS = 32;
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] slot_evt = '0, slot_evt_rx = '0, reg_wdata = '0;
  logic [2:0]    err_evt = '0, reg_addr = '0;
  logic          reg_wr = 1'b0;
  logic [NS-1:0] reg_rdata;
  logic          irq_tx, irq_rx, irq_err, irq_comb;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state built from the requirements
  logic          m_sep;
  logic [NS-1:0] m_stat, m_mask, m_dir;
  logic [2:0]    m_estat, m_emask;
  logic [3:0]    m_flags;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_irq_aggr #(.NSLOT(NS)) i_can_irq_aggr (
    .clk(clk), .rst_n(rst_n), .slot_evt(slot_evt), .slot_evt_rx(slot_evt_rx),
    .err_evt(err_evt), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err),
    .irq_comb(irq_comb)
  );

  task automatic chk(input string tag, input logic [NS-1:0] act, input logic [NS-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void model_reset();
    m_sep = 0; m_stat = '0; m_mask = '0; m_dir = '0;
    m_estat = '0; m_emask = '0; m_flags = '0;
  endfunction

  function automatic void model_step(input logic [NS-1:0] e, input logic [NS-1:0] r,
                                     input logic [2:0] ee, input logic w,
                                     input logic [2:0] a, input logic [NS-1:0] d);
    logic tx, rx, enew, eany;
    logic [3:0] set, clr;
    tx   = |(e & ~r & m_mask);
    rx   = |(e & r & m_mask);
    enew = |(ee & m_emask);
    eany = |(m_estat & m_emask);
    set  = m_sep ? {1'b0, enew & ~eany, rx, tx} : {tx | rx | enew, 3'b000};
    clr  = (w && a == 3'd6) ? d[3:0] : 4'h0;
    m_flags = (m_flags & ~clr) | set;
    m_stat  = (m_stat & ~((w && a == 3'd1) ? ~d : '0)) | e;
    m_dir   = (m_dir & ~e) | (r & e);
    m_estat = (m_estat & ~((w && a == 3'd4) ? ~d[2:0] : 3'b000)) | ee;
    if (w && a == 3'd2) m_mask  = d;
    if (w && a == 3'd5) m_emask = d[2:0];
    if (w && a == 3'd0) m_sep   = d[0];
  endfunction

  task automatic cyc(input logic [NS-1:0] e, input logic [NS-1:0] r, input logic [2:0] ee,
                     input logic w, input logic [2:0] a, input logic [NS-1:0] d);
    @(negedge clk);
    slot_evt = e; slot_evt_rx = r; err_evt = ee; reg_wr = w; reg_addr = a; reg_wdata = d;
    model_step(e, r, ee, w, a, d);
    @(posedge clk); #1;
    slot_evt = '0; slot_evt_rx = '0; err_evt = '0; reg_wr = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [NS-1:0] d);
    cyc('0, '0, 3'b000, 1'b1, a, d);
  endtask

  task automatic rd(input logic [2:0] a, output logic [NS-1:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic check_all();
    logic [NS-1:0] v;
    chk("R6 irq_tx", NS'(irq_tx), NS'(m_flags[0]));
    chk("R6 irq_rx", NS'(irq_rx), NS'(m_flags[1]));
    chk("R7 irq_err", NS'(irq_err), NS'(m_flags[2]));
    chk("R8 irq_comb", NS'(irq_comb), NS'(m_flags[3]));
    rd(3'd0, v); chk("R2 routing bit", v, NS'(m_sep));
    rd(3'd1, v); chk("R4 slot status", v, m_stat);
    rd(3'd2, v); chk("R2 slot mask", v, m_mask);
    rd(3'd3, v); chk("R3 slot direction", v, m_dir);
    rd(3'd4, v); chk("R5 error status", v, NS'(m_estat));
    rd(3'd5, v); chk("R2 error mask", v, NS'(m_emask));
    rd(3'd6, v); chk("R9 request flags", v, NS'(m_flags));
    rd(3'd7, v); chk("R2 reserved address", v, '0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [NS-1:0] v;
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R1 irq_tx in reset", NS'(irq_tx), '0);
    chk("R1 irq_comb in reset", NS'(irq_comb), '0);
    rd(3'd1, v); chk("R1 status in reset", v, '0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check_all();

    // separate mode, slot 3 and all error causes enabled
    wr(3'd0, 1); wr(3'd2, 32'h0000_0008); wr(3'd5, 7);
    check_all();
    // R6 transmit, then re-trigger while status still 1
    cyc(32'h8, 32'h0, 0, 0, 0, 0); chk("R6 tx flag raised", NS'(irq_tx), 1);
    wr(3'd6, 4'b0001);             chk("R9 tx flag cleared", NS'(irq_tx), 0);
    cyc(32'h8, 32'h0, 0, 0, 0, 0); chk("R6 tx re-trigger on set status", NS'(irq_tx), 1);
    cyc(32'h8, 32'h8, 0, 0, 0, 0); chk("R6 rx flag raised", NS'(irq_rx), 1);
    rd(3'd3, v); chk("R3 direction receive", v & 32'h8, 32'h8);
    check_all();
    // R10 masked slot event
    wr(3'd6, 4'hF);
    cyc(32'h20, 32'h0, 0, 0, 0, 0);
    chk("R10 masked event no tx", NS'(irq_tx), 0);
    rd(3'd1, v); chk("R10 masked event sets status", v & 32'h20, 32'h20);
    // R7 error suppression and release
    cyc(0, 0, 3'b001, 0, 0, 0); chk("R7 first error raises", NS'(irq_err), 1);
    wr(3'd6, 4'b0100);
    cyc(0, 0, 3'b010, 0, 0, 0); chk("R7 second error suppressed", NS'(irq_err), 0);
    wr(3'd4, 0);
    cyc(0, 0, 3'b100, 0, 0, 0); chk("R7 error after clear raises", NS'(irq_err), 1);
    // R7 masked status does not suppress
    wr(3'd6, 4'hF); wr(3'd4, 0); wr(3'd5, 3'b010);
    cyc(0, 0, 3'b001, 0, 0, 0); chk("R10 masked error silent", NS'(irq_err), 0);
    cyc(0, 0, 3'b010, 0, 0, 0); chk("R7 masked pending ignored", NS'(irq_err), 1);
    check_all();
    // R4 / R5 collision: event wins over clear
    cyc(32'h80, 0, 3'b100, 1, 3'd1, 0);
    rd(3'd1, v); chk("R4 event beats clear", v, 32'h80);
    cyc(0, 0, 3'b100, 1, 3'd4, 0);
    rd(3'd4, v); chk("R5 event beats clear", v, 32'h4);
    // R9 set beats clear
    wr(3'd6, 4'hF);
    cyc(32'h8, 0, 0, 1, 3'd6, 4'b0001); chk("R9 set beats clear", NS'(irq_tx), 1);
    check_all();
    // R8 combined mode, errors re-trigger
    wr(3'd6, 4'hF); wr(3'd0, 0); wr(3'd5, 7);
    cyc(0, 0, 3'b001, 0, 0, 0); chk("R8 comb raised", NS'(irq_comb), 1);
    chk("R8 err flag quiet", NS'(irq_err), 0);
    wr(3'd6, 4'b1000);
    cyc(0, 0, 3'b010, 0, 0, 0); chk("R8 comb re-trigger", NS'(irq_comb), 1);
    check_all();

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [NS-1:0] e, r, d;
      logic [2:0] ee, a;
      logic w;
      e  = $urandom & $urandom & $urandom & $urandom;
      r  = $urandom;
      ee = (($urandom % 4) == 0) ? 3'($urandom) : 3'b000;
      w  = ($urandom % 3) == 0;
      a  = 3'($urandom % 8);
      d  = $urandom;
      if (a == 3'd1 || a == 3'd4) d = d | $urandom;
      cyc(e, r, ee, w, a, d);
      check_all();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule